// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets logic on a single clock read and write an external asynchronous static RAM of 32K words by 8 bits. The host issues one command at a time on a request/acknowledge port: it pulses a request with a 15-bit address, a read/write flag and write data. The controller then runs the memory's chip select, output enable and write enable through a fixed sequence: idle, setup, access (read) or strobe (write), hold/turnaround, and back to idle. It finishes with a one-cycle acknowledge, which carries the read byte on reads.

The data bus is split into an output value, an output-enable flag and an input value, so the pad ring can build the tri-state buffer. Every phase length is computed at elaboration from timing limits given in picoseconds and the clock period. The count is the ceiling of limit over period, and at least one cycle. A parameter chooses whether output enable stays low during writes. When it does, the write strobe is stretched to cover the memory's output turn-off time plus data setup. The controller's own bus driver is also held back until the memory has let go of the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and after it, with no request, chip select, output enable and write enable are high (inactive), the data-bus driver flag is low and the acknowledge is low.
- R2: A read request sampled in idle returns the byte last written to that address on `rd_data`. With the default timing (8 ns clock), the acknowledge is seen 3 clock cycles after the request is driven.
- R3: A write request sampled in idle stores `req_wdata` at `req_addr`. With the default timing, the acknowledge is seen 4 clock cycles after the request is driven.
- R4: Control encoding on the memory pins: idle has chip select high. A read drives chip select low, output enable low and write enable high. A write drives write enable low only while chip select is low.
- R5: The memory address does not change while chip select stays low.
- R6: Every write strobe (write enable low) lasts at least the minimum pulse width (8 ns). When output enable is low it lasts at least the turn-off time plus data setup (5 + 6 ns). Data is driven at least 6 ns before the strobe rises, and chip select and address are valid at least 8 ns before that.
- R7: The controller drives the data bus only from the second strobe cycle onward, never while the memory may still be driving it, and never with output enable low and write enable high.
- R8: Read data is captured no earlier than 10 ns after address and chip select become valid, and 6 ns after output enable falls.
- R9: A request raised while a command is in progress is ignored: it produces no acknowledge and changes no memory content.
- R10: The acknowledge is a single-cycle pulse, given while chip select is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Command request, sampled only in idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Command address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result, valid with `ack` after a read |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | High while the controller drives the data bus |
| mem_dq_i | input | 8 | Value seen on the data bus |

## Verification
The bench drives a behavioural memory model. The model gives unknown data until its access times have passed, drives the bus for a turn-off tail after release, and times every strobe. Write-then-read patterns at both address ends and at alternating-bit addresses, using all-zero, all-one and alternating data, show whether writes land at the right word with the right value. Reads that follow writes, and writes that follow reads, show whether the turnaround and driver-delay rules avoid contention. An overwrite, and a request raised mid-command, show whether stale data or extra commands slip through. Per-cycle checks of the pins during a read and a write confirm the control encoding and when the driver turns on.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing values are non-negative picosecond integers.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_STROBE,
        ST_HOLD
    } asram_state_e;

    // Whole clock cycles covering a limit, never fewer than one.
    function automatic int ps_to_cyc(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
`timescale 1ns/1ps
// Loadable down-counter that measures the length of one sequencer phase.
// Assumes load has priority; the counter rests at zero once a phase ends.
module asram_phase_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Flag the last cycle of a phase.
    always_comb zero = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Command sequencer: walks idle -> setup -> access/strobe -> hold -> idle
// and decodes the memory control pins from the registered state.
// Assumes N_WP > N_DRV so the driver window inside the strobe is non-empty.
module asram_seq
    import asram_pkg::*;
#(
    parameter int W         = 2,
    parameter int N_RD      = 1,
    parameter int N_WP      = 2,
    parameter int N_DRV     = 1,
    parameter int N_RHOLD   = 1,
    parameter int N_WHOLD   = 1,
    parameter bit WR_OE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_wr,
    output logic accept,
    output logic capture,
    output logic op_done,
    output logic mem_cs_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic mem_dq_oe
);

    localparam logic [W-1:0] RD_LD    = W'(N_RD - 1);
    localparam logic [W-1:0] WP_LD    = W'(N_WP - 1);
    localparam logic [W-1:0] RH_LD    = W'(N_RHOLD - 1);
    localparam logic [W-1:0] WH_LD    = W'(N_WHOLD - 1);
    localparam logic [W-1:0] DRV_LIM  = W'(N_WP - 1 - N_DRV);

    asram_state_e st, nxt;
    logic         wr_q;
    logic         load;
    logic [W-1:0] load_val;
    logic [W-1:0] cnt;
    logic         zero;

    asram_phase_cnt #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .cnt      (cnt),
        .zero     (zero)
    );

    // Next-state selection and phase length to load on each transition.
    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        unique case (st)
            ST_IDLE: if (req) begin
                nxt  = ST_SETUP;
                load = 1'b1;
            end
            ST_SETUP: if (zero) begin
                nxt      = wr_q ? ST_STROBE : ST_ACCESS;
                load     = 1'b1;
                load_val = wr_q ? WP_LD : RD_LD;
            end
            ST_ACCESS: if (zero) begin
                nxt      = ST_HOLD;
                load     = 1'b1;
                load_val = RH_LD;
            end
            ST_STROBE: if (zero) begin
                nxt      = ST_HOLD;
                load     = 1'b1;
                load_val = WH_LD;
            end
            ST_HOLD: if (zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Latch the command direction when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (accept) wr_q <= req_wr;
    end

    // Handshake strobes toward the data path.
    always_comb begin
        accept  = (st == ST_IDLE) && req;
        capture = (st == ST_ACCESS) && zero;
        op_done = ((st == ST_ACCESS) || (st == ST_STROBE)) && zero;
    end

    // Memory pin decode from the registered state.
    always_comb begin
        mem_cs_n  = (st == ST_IDLE);
        mem_we_n  = (st != ST_STROBE);
        mem_oe_n  = !(((st == ST_SETUP) || (st == ST_ACCESS) || (st == ST_STROBE))
                      && (!wr_q || WR_OE_LOW));
        mem_dq_oe = (st == ST_STROBE) && (cnt <= DRV_LIM);
    end

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
// Data path: holds address and write data for the whole command,
// captures the read byte and produces the acknowledge pulse.
// Assumes accept, capture and op_done are single-cycle strobes.
module asram_dpath #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          op_done,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] rd_data,
    output logic          ack
);

    // Hold address and write data stable from setup through hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Sample the bus on the edge that ends the read access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= mem_dq_i;
    end

    // One-cycle acknowledge when the access or strobe phase finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= op_done;
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Derives every phase length
// from picosecond limits and CLK_PS, then wires sequencer and data path.
// Assumes one memory device and single commands (no bursts).
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_RC_PS   = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_OE_PS   = 6000,
    parameter int T_WC_PS   = 10000,
    parameter int T_WP_PS   = 8000,
    parameter int T_AW_PS   = 8000,
    parameter int T_DW_PS   = 6000,
    parameter int T_WHZ_PS  = 5000,
    parameter int T_HZ_PS   = 5000,
    parameter bit WR_OE_LOW = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    // Read access after the one-cycle setup (setup already counts once).
    localparam int N_RD = imax(1, imax(ps_to_cyc(T_AA_PS, CLK_PS) - 1,
                          imax(ps_to_cyc(T_OE_PS, CLK_PS) - 1,
                               ps_to_cyc(T_RC_PS, CLK_PS) - 1)));
    // Strobe cycles before the controller may drive the bus.
    localparam int N_DRV = WR_OE_LOW ? ps_to_cyc(T_WHZ_PS, CLK_PS) : 1;
    // Strobe length: pulse width, driver delay plus setup, select-to-end.
    localparam int N_WP0 = imax(ps_to_cyc(T_WP_PS, CLK_PS),
                           imax(N_DRV + ps_to_cyc(T_DW_PS, CLK_PS),
                                ps_to_cyc(T_AW_PS, CLK_PS) - 1));
    localparam int N_WP  = WR_OE_LOW ?
                           imax(N_WP0, ps_to_cyc(T_WHZ_PS + T_DW_PS, CLK_PS)) : N_WP0;
    localparam int N_RHOLD = imax(ps_to_cyc(T_HZ_PS, CLK_PS),
                                  ps_to_cyc(T_RC_PS, CLK_PS) - 1 - N_RD);
    localparam int N_WHOLD = imax(1, ps_to_cyc(T_WC_PS, CLK_PS) - 1 - N_WP);
    localparam int N_MAX   = imax(imax(N_RD, N_WP), imax(N_RHOLD, N_WHOLD));
    localparam int CW      = imax(1, $clog2(N_MAX + 1));

    logic accept;
    logic capture;
    logic op_done;

    asram_seq #(
        .W         (CW),
        .N_RD      (N_RD),
        .N_WP      (N_WP),
        .N_DRV     (N_DRV),
        .N_RHOLD   (N_RHOLD),
        .N_WHOLD   (N_WHOLD),
        .WR_OE_LOW (WR_OE_LOW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .accept    (accept),
        .capture   (capture),
        .op_done   (op_done),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .op_done   (op_done),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rd_data   (rd_data),
        .ack       (ack)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM controller pins, bound to the top module.
// Assumes the synchronous active-low reset of the controller.
module asram_ctrl_chk #(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);

    // Write strobe only inside a selected cycle.
    assert_strobe_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    // Address held while the chip stays selected.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // Driver on only after write enable has been low a full cycle.
    assert_drive_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n)));

    // No driver while the memory is told to output.
    assert_no_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe);

    // Acknowledge is a single pulse.
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // Acknowledge falls inside the selected cycle.
    assert_ack_selected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !mem_cs_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench with a timed memory model for the SRAM controller.
module asram_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem  [int];
    logic [7:0] refm [int];
    real  t_cs = -100.0, t_oe = -100.0, t_addr = -100.0, t_rel = -100.0;
    real  t_wef = -100.0, t_wer = -100.0;
    logic mdrv = 1'b0;
    logic [7:0] mval = 8'h00;
    logic p_cs_n = 1'b1, p_oe_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dq_o = '0;
    bit   clash = 1'b0;

    always @(negedge mem_cs_n) t_cs = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(mem_addr)         t_addr = $realtime;
    always @(negedge mem_we_n) t_wef = $realtime;
    always @(posedge mem_we_n) t_wer = $realtime;
    always @(posedge mem_cs_n or posedge mem_oe_n or negedge mem_we_n) t_rel = $realtime;

    always_comb mem_dq_i = mem_dq_oe ? mem_dq_o : (mdrv ? mval : 8'hzz);

    function automatic logic [7:0] mem_rd(input logic [14:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic model_step();
        real now;
        bit  rd_on, valid;
        real need;
        now   = $realtime;
        rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
        mdrv  = rd_on || (now < t_rel + 5.0);
        valid = rd_on && (now - t_cs >= 10.0) && (now - t_oe >= 6.0) && (now - t_addr >= 10.0);
        mval  = valid ? mem_rd(mem_addr) : 8'hxx;
        // R7: controller driver against memory drive window
        if (mem_dq_oe && mdrv && !clash)
            chk(1'b0, "R7", "bus contention", 1, 0);
        clash = mem_dq_oe && mdrv;
        // R5: address stable while selected
        if (!mem_cs_n && !p_cs_n && mem_addr != p_addr)
            chk(1'b0, "R5", "address moved while selected", 32'(mem_addr), 32'(p_addr));
        // R6: end of a write strobe
        if (!p_we_n && mem_we_n) begin
            need = p_oe_n ? 8.0 : 11.0;
            chk(!p_cs_n, "R6", "chip selected at strobe end", 32'(p_cs_n), 0);
            chk(t_wer - t_wef >= need, "R6", "strobe width ps",
                32'($rtoi((t_wer - t_wef) * 1000.0)), 32'($rtoi(need * 1000.0)));
            chk(p_dq_oe, "R6", "data driven at strobe end", 32'(p_dq_oe), 1);
            chk(t_wer - t_cs >= 8.0 && t_wer - t_addr >= 8.0, "R6",
                "select/address before strobe end ps",
                32'($rtoi((t_wer - t_cs) * 1000.0)), 8000);
            mem[int'(p_addr)] = p_dq_o;
        end
        p_cs_n = mem_cs_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
        p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq_o = mem_dq_o;
    endtask

    // R6 data setup: data must not change during the last 6 ns of a strobe
    real t_data = -100.0;
    always @(mem_dq_o)          t_data = $realtime;
    always @(posedge mem_dq_oe) t_data = $realtime;
    always @(posedge mem_we_n) begin
        if (!mem_cs_n)
            chk($realtime - t_data >= 6.0, "R6", "data setup ps",
                32'($rtoi(($realtime - t_data) * 1000.0)), 6000);
    end

    initial begin
        #0.05;
        forever begin
            model_step();
            #0.1;
        end
    end

    // ---------------- host tasks ----------------
    task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          input int exp_lat, input string tag, output logic [7:0] got);
        int lat;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, tag, "ack latency", 32'(lat), 32'(exp_lat));
        got = rd_data;
        @(negedge clk);
        chk(!ack, "R10", "ack single cycle", 32'(ack), 0);
    endtask

    task automatic t_write(input logic [14:0] a, input logic [7:0] d);
        logic [7:0] unused_rd;
        do_req(1'b1, a, d, 4, "R3", unused_rd);
        refm[int'(a)] = d;
    endtask

    task automatic t_read(input logic [14:0] a);
        logic [7:0] got, exp;
        exp = refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
        do_req(1'b0, a, 8'h00, 3, "R2", got);
        chk(got === exp, "R2_R8", "read data", 32'(got), 32'(exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "controls idle in reset",
            {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !ack, "R1", "driver and ack low in reset",
            {30'd0, mem_dq_oe, ack}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1",
            "idle after reset", {27'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);
    endtask

    task automatic t_pins();
        // Read: cs=0 oe=0 we=1 during setup
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = 15'h0123;
        @(negedge clk);
        req = 1'b0;
        chk(!mem_cs_n && !mem_oe_n && mem_we_n, "R4", "read encoding",
            {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 1);
        while (!ack) @(negedge clk);
        @(negedge clk);
        // Write: strobe low, driver delayed one cycle
        req = 1'b1; req_wr = 1'b1; req_addr = 15'h0123; req_wdata = 8'h3C;
        @(negedge clk);
        req = 1'b0;
        chk(!mem_cs_n && mem_we_n, "R4", "write setup encoding",
            {30'd0, mem_cs_n, mem_we_n}, 1);
        @(negedge clk);
        chk(!mem_we_n && !mem_cs_n && !mem_dq_oe, "R7", "first strobe cycle undriven",
            {29'd0, mem_we_n, mem_cs_n, mem_dq_oe}, 0);
        @(negedge clk);
        chk(!mem_we_n && mem_dq_oe, "R7", "second strobe cycle driven",
            {30'd0, mem_we_n, mem_dq_oe}, 1);
        @(negedge clk);
        chk(ack && mem_we_n, "R3", "strobe ended with ack", {30'd0, ack, mem_we_n}, 3);
        @(negedge clk);
        chk(mem_cs_n && !ack, "R4", "deselected in idle", {30'd0, mem_cs_n, ack}, 2);
        refm[int'(15'h0123)] = 8'h3C;
        t_read(15'h0123);
    endtask

    task automatic t_patterns();
        logic [14:0] addrs [4] = '{15'h0000, 15'h7FFF, 15'h5555, 15'h2AAA};
        logic [7:0]  datas [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        for (int i = 0; i < 4; i++) t_write(addrs[i], datas[i]);
        for (int i = 0; i < 4; i++) t_read(addrs[i]);
        for (int i = 0; i < 8; i++) t_write(15'(1 << i), 8'(1 << i));
        for (int i = 0; i < 8; i++) t_read(15'(1 << i));
    endtask

    task automatic t_turnaround();
        // Back-to-back alternation exercises read->write driver timing (R7)
        for (int i = 0; i < 6; i++) begin
            t_write(15'h1000 + 15'(i), 8'hC0 ^ 8'(i));
            t_read(15'h1000 + 15'(i));
            t_write(15'h1000 + 15'(i), 8'h0F ^ 8'(i));   // overwrite
            t_read(15'h1000 + 15'(i));
        end
    endtask

    task automatic t_busy_ignore();
        int acks;
        acks = 0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 15'h0777; req_wdata = 8'h11;
        @(negedge clk);
        if (ack) acks++;
        req_wdata = 8'h99;              // arrives in setup: must be ignored
        @(negedge clk);
        if (ack) acks++;
        req_wr = 1'b0; req_addr = 15'h0001;  // read while in strobe: ignored
        @(negedge clk);
        if (ack) acks++;
        req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack) acks++;
        end
        chk(acks == 1, "R9", "acks for one accepted command", 32'(acks), 1);
        refm[int'(15'h0777)] = 8'h11;
        t_read(15'h0777);
        t_read(15'h0001);
    endtask

    initial begin
        #(8.0 * 150000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_pins();
        t_patterns();
        t_turnaround();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule